// File: doc/BRIEF.md
# Multi-Mode DMA Channel Priority Arbiter

This block decides which DMA channel is served next. It watches a request vector of eight channel slots, of which six (0 to 5) are populated. It grants exactly one requesting channel at a time. A two-bit field in a 16-bit global control word selects the policy. Three policies are fixed priority rankings, each a different permutation of the channels. The fourth is a rotating policy that starts its search just after the most recently served channel.

A grant is registered and stays in place until the granted channel pulses its done line to say its transfer unit has finished. The grant drops on the next edge. The following cycle is the arbitration cycle for the next decision, so there is one idle cycle between grants.

No new grant is issued while the global enable bit is clear or while the halt or address-error flag is raised. A grant already in place runs to its done pulse. All pins are plain control and status signals: the grant is a level held under the done handshake, and there is no data stream.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grant_o is 0, grant_idx_o is 0 and grant_vld_o is 0.
- R2: With mode field ctrl_i[9:8] = 0, the highest to lowest priority is 0,1,2,3,4,5,6,7.
- R3: With mode field ctrl_i[9:8] = 1, the highest to lowest priority is 0,2,3,1,4,6,7,5.
- R4: With mode field ctrl_i[9:8] = 2, the highest to lowest priority is 2,0,1,3,6,4,5,7.
- R5: With mode field ctrl_i[9:8] = 3, the search starts at the channel after the most recently granted one and wraps from 7 to 0. The most recently granted channel is updated on every grant in every mode, and after reset the search starts at channel 0.
- R6: Requests on channels 6 and 7 are ignored and never produce a grant.
- R7: No grant is issued while the enable bit ctrl_i[0] is 0, halt_i is 1 or addr_err_i is 1. Once all three conditions clear, a pending request is granted at the next edge.
- R8: A grant stays stable until done_i pulses for the granted channel. A done pulse on any other channel has no effect.
- R9: A new decision is registered at the edge that follows a cycle with no grant. After the granted channel's done pulse, the grant drops at the next edge and a new grant can appear one edge later.
- R10: A change of mode while a grant is held affects only the next arbitration decision.
- R11: While granted, grant_o is one-hot with the bit at position grant_idx_o and grant_vld_o is 1. While idle, grant_o and grant_idx_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Per-channel request levels |
| ctrl_i | input | 16 | Global control word: bit 0 enable, bits 9:8 mode |
| halt_i | input | 1 | Global halt flag, blocks new grants |
| addr_err_i | input | 1 | Global address-error flag, blocks new grants |
| done_i | input | 8 | Per-channel unit-finished pulses |
| grant_o | output | 8 | One-hot grant |
| grant_idx_o | output | 3 | Encoded granted channel |
| grant_vld_o | output | 1 | A grant is held |

## Verification
On every cycle, the assertions check these rules:
- A newly issued grant goes to a populated channel that was requesting.
- No grant starts while the block is blocked.
- A held grant stays fixed until its own done pulse and then drops.
- Each picker returns a requesting channel.

Only the bench scenarios can show that the chosen channel is the right one under each of the three rankings and the rotation. They also show that the rotation pointer carries over across mode changes, and that a mode change during a hold affects only the next decision.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int ARB_CH       = 8;
  localparam int ARB_IDX_W    = $clog2(ARB_CH);
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MODE_LO = 8;

  typedef enum logic [1:0] {
    MODE_RANK_A = 2'd0,
    MODE_RANK_B = 2'd1,
    MODE_RANK_C = 2'd2,
    MODE_ROTATE = 2'd3
  } arb_mode_e;

  // Channel that occupies rank slot 'slot' (0 = highest) under a fixed mode.
  function automatic logic [ARB_IDX_W-1:0] rank_channel(arb_mode_e m, int unsigned slot);
    logic [ARB_IDX_W-1:0] rb [ARB_CH];
    logic [ARB_IDX_W-1:0] rc [ARB_CH];
    rb = '{3'd0, 3'd2, 3'd3, 3'd1, 3'd4, 3'd6, 3'd7, 3'd5};
    rc = '{3'd2, 3'd0, 3'd1, 3'd3, 3'd6, 3'd4, 3'd5, 3'd7};
    case (m)
      MODE_RANK_B: return rb[slot];
      MODE_RANK_C: return rc[slot];
      default:     return ARB_IDX_W'(slot);
    endcase
  endfunction
endpackage

// File: rtl/dma_arb_fixed.sv
module dma_arb_fixed
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = ARB_CH,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  arb_mode_e         mode,
  output logic              hit_any,
  output logic [IDX_W-1:0]  pick
);
  logic [NUM_CH-1:0] slot_hit;
  logic [IDX_W-1:0]  slot_ch [NUM_CH];

  for (genvar s = 0; s < NUM_CH; s++) begin : g_slot
    assign slot_ch[s]  = rank_channel(mode, s);
    assign slot_hit[s] = req[slot_ch[s]];
  end

  always_comb begin
    pick = '0;
    for (int s = NUM_CH - 1; s >= 0; s--) begin
      if (slot_hit[s]) pick = slot_ch[s];
    end
  end

  assign hit_any = |slot_hit;

  // R2 R3 R4: the ranked choice is always a requesting channel
  p_fixed_pick_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> req[pick]);
endmodule

// File: rtl/dma_arb_rotate.sv
module dma_arb_rotate #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  last,
  output logic [IDX_W-1:0]  pick
);
  logic [NUM_CH:1]   step_hit;
  logic [IDX_W-1:0]  step_ch [NUM_CH+1];

  assign step_ch[0] = last;
  for (genvar k = 1; k <= NUM_CH; k++) begin : g_step
    assign step_ch[k]  = last + IDX_W'(k);
    assign step_hit[k] = req[step_ch[k]];
  end

  always_comb begin
    pick = '0;
    for (int k = NUM_CH; k >= 1; k--) begin
      if (step_hit[k]) pick = step_ch[k];
    end
  end

  // R5: the rotating choice is always a requesting channel
  p_rotate_pick_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> req[pick]);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = ARB_CH,
  parameter int POP_CH = 6,
  parameter int CTRL_W = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              halt_i,
  input  logic              addr_err_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              grant_vld_o
);
  localparam logic [NUM_CH-1:0] POP_MASK = NUM_CH'((1 << POP_CH) - 1);

  logic [NUM_CH-1:0] req_m;
  logic              allow;
  arb_mode_e         mode;
  logic              fx_any;
  logic [IDX_W-1:0]  fx_pick, rr_pick, pick;
  logic              busy;
  logic [IDX_W-1:0]  cur, last;

  assign req_m = req_i & POP_MASK;
  assign mode  = arb_mode_e'(ctrl_i[CTRL_MODE_LO +: 2]);
  assign allow = ctrl_i[CTRL_EN_BIT] && !halt_i && !addr_err_i;

  dma_arb_fixed #(.NUM_CH(NUM_CH)) u_fixed (
    .clk(clk), .rst_n(rst_n), .req(req_m), .mode(mode),
    .hit_any(fx_any), .pick(fx_pick)
  );

  dma_arb_rotate #(.NUM_CH(NUM_CH)) u_rotate (
    .clk(clk), .rst_n(rst_n), .req(req_m), .last(last), .pick(rr_pick)
  );

  assign pick = (mode == MODE_ROTATE) ? rr_pick : fx_pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      last <= IDX_W'(NUM_CH - 1);
    end else if (busy) begin
      if (done_i[cur]) begin
        busy <= 1'b0;
        cur  <= '0;
      end
    end else if (allow && fx_any) begin
      busy <= 1'b1;
      cur  <= pick;
      last <= pick;
    end
  end

  assign grant_vld_o = busy;
  assign grant_idx_o = cur;
  assign grant_o     = busy ? (NUM_CH'(1) << cur) : '0;

  // R6: a fresh grant lands on a populated channel that was requesting
  p_grant_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld_o) |-> |($past(req_m) & grant_o));

  // R7: nothing new is granted while blocked
  p_blocked_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !allow) |=> !grant_vld_o);

  // R8: grant held until its own done pulse
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !done_i[grant_idx_o]) |=> (grant_vld_o && $stable(grant_o)));

  // R9: done from the granted channel releases at the next edge
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && done_i[grant_idx_o]) |=> !grant_vld_o);
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic [15:0] ctrl_i = '0;
  logic       halt_i = 1'b0;
  logic       addr_err_i = 1'b0;
  logic [7:0] done_i = '0;
  logic [7:0] grant_o;
  logic [2:0] grant_idx_o;
  logic       grant_vld_o;

  always #5 clk = ~clk;

  dma_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ctrl_i(ctrl_i),
    .halt_i(halt_i), .addr_err_i(addr_err_i), .done_i(done_i),
    .grant_o(grant_o), .grant_idx_o(grant_idx_o), .grant_vld_o(grant_vld_o)
  );

  int total = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  int ord [3][8];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  bit m_busy = 0;
  int m_idx = 0, m_last = 7;

  function automatic int model_pick(int md, logic [7:0] rq, int lst);
    if (md < 3) begin
      foreach (ord[md][p]) if (ord[md][p] < 6 && rq[ord[md][p]]) return ord[md][p];
    end else begin
      for (int k = 1; k <= 8; k++) if ((lst + k) % 8 < 6 && rq[(lst + k) % 8]) return (lst + k) % 8;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_last = 7;
    end else if (m_busy) begin
      if (done_i[m_idx]) begin m_busy = 0; m_idx = 0; end
    end else if (ctrl_i[0] && !halt_i && !addr_err_i && (req_i & 8'h3f) != 0) begin
      m_idx = model_pick(int'(ctrl_i[9:8]), req_i, m_last);
      m_busy = 1; m_last = m_idx;
    end
  end

  always @(negedge clk) begin
    chk(grant_vld_o == m_busy, cur_req, "grant_vld_o", grant_vld_o, m_busy);
    chk(grant_o == (m_busy ? 8'(1 << m_idx) : 8'h0), cur_req, "grant_o", grant_o,
        m_busy ? (1 << m_idx) : 0);
    chk(grant_idx_o == 3'(m_idx), cur_req, "grant_idx_o", grant_idx_o, m_idx);
  end

  always @(posedge clk) if (cyc > 20000) begin
    fails++; total++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic set_mode(int md, bit en);
    ctrl_i = '0;
    ctrl_i[9:8] = 2'(md);
    ctrl_i[0] = en;
  endtask

  task automatic do_grant(logic [7:0] rq, int md, int exp, string tag);
    cur_req = tag;
    @(negedge clk);
    set_mode(md, 1'b1);
    req_i = rq;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (grant_vld_o) break;
    end
    chk(grant_vld_o && grant_idx_o == 3'(exp), tag, "granted channel", grant_idx_o, exp);
    done_i = 8'(1 << exp);
    req_i = '0;
    @(negedge clk);
    done_i = '0;
  endtask

  initial begin
    ord[0] = '{0, 1, 2, 3, 4, 5, 6, 7};
    ord[1] = '{0, 2, 3, 1, 4, 6, 7, 5};
    ord[2] = '{2, 0, 1, 3, 6, 4, 5, 7};
    set_mode(0, 1'b1);
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk(grant_o == 0 && grant_idx_o == 0 && !grant_vld_o, "R1", "reset outputs", grant_o, 0);
    rst_n = 1'b1;

    do_grant(8'h3c, 0, 2, "R2");
    do_grant(8'h30, 0, 4, "R2");
    do_grant(8'h0a, 1, 3, "R3");
    do_grant(8'h32, 1, 1, "R3");
    do_grant(8'h30, 1, 4, "R3");
    do_grant(8'h07, 2, 2, "R4");
    do_grant(8'h3b, 2, 0, "R4");
    do_grant(8'h38, 2, 3, "R4");
    do_grant(8'h30, 2, 4, "R4");

    cur_req = "R6";
    set_mode(0, 1'b1); req_i = 8'hc0;
    repeat (4) @(negedge clk);
    chk(!grant_vld_o, "R6", "no grant for channels 6/7", grant_vld_o, 0);
    req_i = '0;
    do_grant(8'he0, 0, 5, "R6");

    do_grant(8'h3f, 3, 0, "R5");
    do_grant(8'h3f, 3, 1, "R5");
    do_grant(8'h3f, 3, 2, "R5");
    do_grant(8'h21, 3, 5, "R5");
    do_grant(8'h21, 3, 0, "R5");

    cur_req = "R7";
    @(negedge clk);
    set_mode(0, 1'b0); req_i = 8'h01;
    repeat (4) @(negedge clk);
    chk(!grant_vld_o, "R7", "enable clear", grant_vld_o, 0);
    set_mode(0, 1'b1); halt_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!grant_vld_o, "R7", "halt set", grant_vld_o, 0);
    halt_i = 1'b0; addr_err_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!grant_vld_o, "R7", "address error set", grant_vld_o, 0);
    addr_err_i = 1'b0;
    @(negedge clk);
    chk(grant_vld_o && grant_idx_o == 0, "R7", "grant after unblock", grant_idx_o, 0);
    done_i = 8'h01; req_i = '0;
    @(negedge clk); done_i = '0;

    cur_req = "R8";
    req_i = 8'h08;
    repeat (2) @(negedge clk);
    done_i = 8'h04;
    @(negedge clk); done_i = '0;
    @(negedge clk);
    chk(grant_vld_o && grant_o == 8'h08, "R8", "held despite foreign done", grant_o, 8);
    done_i = 8'h08; req_i = '0;
    @(negedge clk); done_i = '0;
    chk(!grant_vld_o, "R8", "released by own done", grant_vld_o, 0);

    cur_req = "R9";
    req_i = 8'h03;
    repeat (2) @(negedge clk);
    done_i = 8'h01;
    @(negedge clk); done_i = '0;
    chk(!grant_vld_o, "R9", "idle cycle after done", grant_vld_o, 0);
    @(negedge clk);
    chk(grant_vld_o && grant_idx_o == 0, "R9", "regrant one edge later", grant_idx_o, 0);
    done_i = 8'h01; req_i = '0;
    @(negedge clk); done_i = '0;

    cur_req = "R10";
    req_i = 8'h06;
    repeat (2) @(negedge clk);
    chk(grant_idx_o == 1, "R10", "mode 0 grant", grant_idx_o, 1);
    set_mode(2, 1'b1);
    repeat (2) @(negedge clk);
    chk(grant_vld_o && grant_idx_o == 1, "R10", "held across mode change", grant_idx_o, 1);
    done_i = 8'h02;
    @(negedge clk); done_i = '0;
    @(negedge clk);
    chk(grant_vld_o && grant_idx_o == 2, "R10", "new mode on next decision", grant_idx_o, 2);
    cur_req = "R11";
    chk(grant_o == 8'h04, "R11", "one-hot matches index", grant_o, 4);
    done_i = 8'h04; req_i = '0;
    @(negedge clk); done_i = '0;
    repeat (2) @(negedge clk);
    chk(grant_o == 0 && grant_idx_o == 0, "R11", "idle outputs zero", grant_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule